// File: doc/BRIEF.md
# I2C Slave Address Phase Extension-Code Detector

This block listens to an I2C bus as a slave. Its SCL and SDA inputs have already been synchronised to the system clock. Every START condition opens an address phase. The first eight bits that follow are shifted in, most significant bit first. Seven of them are compared against a local slave address supplied on an input.

A first byte whose top four address bits are all zeros or all ones is treated as a reserved extension code. It raises its own status flag, separate from the address-match flag, and a decoded code type tells software which reserved code arrived. When the local address holds a ten-bit prefix pattern and that same pattern is received, both flags are raised together.

Either flag makes the slave a participant in the transfer and fires a single-cycle interrupt once the falling edge of the eighth SCL clock has been seen. Software can then pulse a release input to drop the slave into standby. The slave stays in standby until the next START.

Top module: `i2c_xc_detect`

## Requirements
- R1: After reset every flag output, code_o, irq_o, active_o and standby_o is 0. A START (SDA falling while SCL is high) clears the bit count and opens a new address phase.
- R2: Bits are sampled on SCL rising edges, MSB first. The first seven bits are the address and the eighth bit is R/W, which is latched on rw_o. Bits after the eighth, up to the next START, do not change any output.
- R3: ext_code_o is set when the upper four received address bits are 0000 or 1111.
- R4: addr_match_o is set when all seven received address bits equal own_addr_i. With own_addr_i = 11110xx and the same address received, both ext_code_o and addr_match_o are set.
- R5: irq_o is a single-cycle pulse one clock after the cycle in which the falling edge of the eighth SCL clock is detected. It fires only when ext_code_o or addr_match_o is set.
- R6: code_o encoding: 0 normal address, 1 general call (0000000 with R/W=0), 2 start byte (0000000 with R/W=1), 3 address 0000001, 4 reserved bus format (0000010), 5 ten-bit prefix (11110xx), 6 any other extension code. code_o is non-zero exactly when ext_code_o is 1.
- R7: active_o goes to 1 with the flags when an extension code or a match is received. It returns to 0 on STOP, on release, or on START.
- R8: A release_i pulse sets standby_o and clears active_o. Until the next START, address evaluation is ignored: no flag, code or irq changes. The next START clears standby_o.
- R9: ext_code_o, addr_match_o, code_o and rw_o hold through STOP until the next START, which clears them. A repeated START without a STOP evaluates the next byte as a fresh address phase.
- R10: If release_i is high in the same cycle as the eighth-clock evaluation, release wins: no irq, flags stay clear, and standby_o becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL |
| sda_i | input | 1 | Synchronised SDA |
| own_addr_i | input | 7 | Local 7-bit slave address |
| release_i | input | 1 | Software release into standby |
| ext_code_o | output | 1 | Extension code received |
| addr_match_o | output | 1 | Address matched own_addr_i |
| rw_o | output | 1 | Latched R/W bit of the address byte |
| code_o | output | 3 | Decoded reserved-code type |
| irq_o | output | 1 | Address-phase interrupt pulse |
| active_o | output | 1 | Slave participating in the transfer |
| standby_o | output | 1 | Slave released until next START |

## Verification
The software release and the eighth-clock address evaluation can fall in the same clock cycle. The bench provokes this by raising release_i in the same cycle that drives SCL low after the eighth bit of an extension-code byte. It judges the outcome at the ports: no interrupt pulse is seen, both flags stay clear and standby is set. A second collision-prone pair is a repeated START that lands while flags are still held. The bench checks that the flags clear at once and that the following byte is decoded afresh.

// File: rtl/i2c_xc_pkg.sv
package i2c_xc_pkg;
  typedef enum logic [2:0] {
    CODE_NONE   = 3'd0,
    CODE_GCALL  = 3'd1,
    CODE_SBYTE  = 3'd2,
    CODE_ADDR1  = 3'd3,
    CODE_RSVD   = 3'd4,
    CODE_TENBIT = 3'd5,
    CODE_EXT    = 3'd6
  } xc_code_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;
endpackage

// File: rtl/i2c_xc_bus_cond.sv
module i2c_xc_bus_cond
  import i2c_xc_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  // idle bus is high, so reset to 1 avoids a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev_o.start = scl_q & scl_i & sda_q & ~sda_i;
    ev_o.stop  = scl_q & scl_i & ~sda_q & sda_i;
    ev_o.rise  = ~scl_q & scl_i;
    ev_o.fall  = scl_q & ~scl_i;
  end
endmodule

// File: rtl/i2c_xc_shifter.sv
module i2c_xc_shifter
  import i2c_xc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_ev_t           ev_i,
  input  logic              sda_i,
  input  logic              done_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              full_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      phase_q <= 1'b0;
    end else if (ev_i.start) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else if (ev_i.stop) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (done_i) begin
      phase_q <= 1'b0;
    end else if (phase_q && ev_i.rise && cnt_q < CNT_W'(BYTE_W)) begin
      sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign byte_o = sh_q;
  assign full_o = phase_q && (cnt_q == CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_xc_decode.sv
module i2c_xc_decode
  import i2c_xc_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned PFX_W  = 4,
  localparam int unsigned TEN_W = PFX_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] own_i,
  output logic              ext_o,
  output logic              match_o,
  output xc_code_e          code_o
);
  logic [ADDR_W-1:0] eq_bits;
  logic [PFX_W-1:0]  pfx;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
    assign eq_bits[i] = ~(addr_i[i] ^ own_i[i]);
  end

  assign pfx     = addr_i[ADDR_W-1 -: PFX_W];
  assign match_o = &eq_bits;
  assign ext_o   = (pfx == '0) || (pfx == '1);

  always_comb begin
    if (addr_i == '0)
      code_o = rw_i ? CODE_SBYTE : CODE_GCALL;
    else if (addr_i == ADDR_W'(1))
      code_o = CODE_ADDR1;
    else if (addr_i == ADDR_W'(2))
      code_o = CODE_RSVD;
    else if (addr_i[ADDR_W-1 -: TEN_W] == {{PFX_W{1'b1}}, 1'b0})
      code_o = CODE_TENBIT;
    else if (ext_o)
      code_o = CODE_EXT;
    else
      code_o = CODE_NONE;
  end
endmodule

// File: rtl/i2c_xc_detect.sv
module i2c_xc_detect
  import i2c_xc_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned PFX_W  = 4,
  localparam int unsigned BYTE_W = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              release_i,
  output logic              ext_code_o,
  output logic              addr_match_o,
  output logic              rw_o,
  output logic [2:0]        code_o,
  output logic              irq_o,
  output logic              active_o,
  output logic              standby_o
);
  bus_ev_t           ev;
  logic [BYTE_W-1:0] byte_w;
  logic              full, done, eval_en;
  logic              dec_ext, dec_match;
  xc_code_e          dec_code;

  logic     ext_q, match_q, rw_q, irq_q, active_q, standby_q;
  xc_code_e code_q;

  i2c_xc_bus_cond u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (ev)
  );

  i2c_xc_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev),
    .sda_i (sda_i),
    .done_i(done),
    .byte_o(byte_w),
    .full_o(full)
  );

  i2c_xc_decode #(.ADDR_W(ADDR_W), .PFX_W(PFX_W)) u_dec (
    .addr_i (byte_w[BYTE_W-1:1]),
    .rw_i   (byte_w[0]),
    .own_i  (own_addr_i),
    .ext_o  (dec_ext),
    .match_o(dec_match),
    .code_o (dec_code)
  );

  // eighth falling edge closes the phase even in standby
  assign done    = full & ev.fall;
  assign eval_en = done & ~standby_q & ~release_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_q     <= 1'b0;
      match_q   <= 1'b0;
      rw_q      <= 1'b0;
      code_q    <= CODE_NONE;
      irq_q     <= 1'b0;
      active_q  <= 1'b0;
      standby_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (ev.start) begin
        ext_q    <= 1'b0;
        match_q  <= 1'b0;
        rw_q     <= 1'b0;
        code_q   <= CODE_NONE;
        active_q <= 1'b0;
      end else if (eval_en) begin
        ext_q    <= dec_ext;
        match_q  <= dec_match;
        rw_q     <= byte_w[0];
        code_q   <= dec_code;
        active_q <= dec_ext | dec_match;
        irq_q    <= dec_ext | dec_match;
      end
      if (ev.stop) active_q <= 1'b0;
      if (release_i) begin
        standby_q <= 1'b1;
        active_q  <= 1'b0;
      end else if (ev.start) begin
        standby_q <= 1'b0;
      end
    end
  end

  assign ext_code_o   = ext_q;
  assign addr_match_o = match_q;
  assign rw_o         = rw_q;
  assign code_o       = code_q;
  assign irq_o        = irq_q;
  assign active_o     = active_q;
  assign standby_o    = standby_q;
endmodule

// File: rtl/i2c_xc_detect_chk.sv
module i2c_xc_detect_chk
  import i2c_xc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       release_i,
  input bus_ev_t    ev,
  input logic       ext_code_o,
  input logic       addr_match_o,
  input logic [2:0] code_o,
  input logic       irq_o,
  input logic       active_o,
  input logic       standby_o
);
  p_irq_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ext_code_o || addr_match_o));

  p_irq_after_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ev.fall));

  p_code_ext_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != 3'd0) == ext_code_o);

  p_active_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (ext_code_o || addr_match_o));

  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> (standby_o && !active_o));

  p_standby_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !irq_o);

  p_start_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev.start |=> (!ext_code_o && !addr_match_o && !active_o));
endmodule

bind i2c_xc_detect i2c_xc_detect_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .release_i   (release_i),
  .ev          (ev),
  .ext_code_o  (ext_code_o),
  .addr_match_o(addr_match_o),
  .code_o      (code_o),
  .irq_o       (irq_o),
  .active_o    (active_o),
  .standby_o   (standby_o)
);

// File: tb/i2c_xc_detect_tb_top.sv
`timescale 1ns/1ps
module i2c_xc_detect_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1, rel = 1'b0;
  logic [6:0] own = 7'h2A;
  logic       ext, mat, rw, irq, act, stb;
  logic [2:0] code;
  int checks = 0, fails = 0, irq_seen = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2c_xc_detect dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .own_addr_i(own), .release_i(rel),
    .ext_code_o(ext), .addr_match_o(mat), .rw_o(rw), .code_o(code),
    .irq_o(irq), .active_o(act), .standby_o(stb)
  );

  always @(negedge clk) if (irq) irq_seen++;

  task automatic chk(string req, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    scl = 1'b0; w(2); sda = 1'b1; w(2); scl = 1'b1; w(2);
    sda = 1'b0; w(2); scl = 1'b0; w(2);
  endtask

  task automatic bus_stop();
    scl = 1'b0; w(2); sda = 1'b0; w(2); scl = 1'b1; w(2); sda = 1'b1; w(2);
  endtask

  task automatic send_bit(logic b);
    sda = b; w(2); scl = 1'b1; w(2); scl = 1'b0; w(2);
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    w(2);
  endtask

  function automatic int exp_ext(logic [7:0] b);
    return (b[7:4] == 4'h0 || b[7:4] == 4'hF) ? 1 : 0;
  endfunction

  function automatic int exp_code(logic [7:0] b);
    logic [6:0] a = b[7:1];
    if (a == 7'd0) return b[0] ? 2 : 1;
    if (a == 7'd1) return 3;
    if (a == 7'd2) return 4;
    if (a[6:2] == 5'b11110) return 5;
    if (exp_ext(b) != 0) return 6;
    return 0;
  endfunction

  task automatic check_byte(logic [7:0] b);
    int e = exp_ext(b);
    int m = (b[7:1] == own) ? 1 : 0;
    chk("R3 ext", int'(ext), e);
    chk("R4 match", int'(mat), m);
    chk("R6 code", int'(code), exp_code(b));
    chk("R2 rw", int'(rw), int'(b[0]));
    chk("R5 irq", irq_seen, (e | m));
    chk("R7 active", int'(act), (e | m));
  endtask

  initial begin
    w(3);
    chk("R1 reset ext", int'(ext), 0);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset code", int'(code), 0);
    chk("R1 reset active", int'(act), 0);
    chk("R1 reset standby", int'(stb), 0);
    rst_n = 1'b1; w(2);

    // R3 R4 R6 sweep: all first bytes for several local addresses
    for (int k = 0; k < 4; k++) begin
      own = (k == 0) ? 7'h2A : (k == 1) ? 7'h78 : (k == 2) ? 7'h00 : 7'h7B;
      for (int v = 0; v < 256; v++) begin
        bus_start();
        irq_seen = 0;
        send_byte(8'(v));
        check_byte(8'(v));
        bus_stop(); w(1);
        chk("R7 stop clears active", int'(act), 0);
        chk("R9 ext held over stop", int'(ext), exp_ext(8'(v)));
      end
    end

    // R4: ten-bit prefix matching own address sets both flags
    own = 7'h7B; bus_start(); irq_seen = 0; send_byte(8'hF6);
    chk("R4 tenbit ext", int'(ext), 1);
    chk("R4 tenbit match", int'(mat), 1);

    // R2: later bits without START leave outputs unchanged
    irq_seen = 0; send_byte(8'h00);
    chk("R2 data ignored ext", int'(ext), 1);
    chk("R2 data ignored code", int'(code), 5);
    chk("R2 data ignored irq", irq_seen, 0);

    // R9: repeated START clears flags, next byte fresh
    bus_start(); w(1);
    chk("R9 rstart clears ext", int'(ext), 0);
    chk("R9 rstart clears match", int'(mat), 0);
    irq_seen = 0; send_byte(8'h54);
    chk("R9 fresh ext", int'(ext), 0);
    chk("R9 fresh code", int'(code), 0);
    chk("R9 fresh irq", irq_seen, 0);
    bus_stop();

    // R8: release after match
    own = 7'h2A; bus_start(); send_byte(8'h54);
    chk("R8 pre active", int'(act), 1);
    rel = 1'b1; w(1); rel = 1'b0; w(1);
    chk("R8 standby set", int'(stb), 1);
    chk("R8 active cleared", int'(act), 0);
    chk("R9 match held in standby", int'(mat), 1);
    bus_stop();

    // R8: release mid-byte ignores the rest of the transfer
    bus_start(); irq_seen = 0;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    rel = 1'b1; w(1); rel = 1'b0;
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    w(2);
    chk("R8 ignored ext", int'(ext), 0);
    chk("R8 ignored irq", irq_seen, 0);
    chk("R8 ignored code", int'(code), 0);
    bus_start();
    chk("R8 start clears standby", int'(stb), 0);
    irq_seen = 0; send_byte(8'h00);
    chk("R8 after standby ext", int'(ext), 1);
    chk("R8 after standby irq", irq_seen, 1);
    bus_stop();

    // R10: release in the evaluation cycle
    bus_start(); irq_seen = 0;
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    sda = 1'b0; w(2); scl = 1'b1; w(2);
    scl = 1'b0; rel = 1'b1; w(1); rel = 1'b0; w(4);
    chk("R10 no irq", irq_seen, 0);
    chk("R10 ext clear", int'(ext), 0);
    chk("R10 standby", int'(stb), 1);
    chk("R1 start opens phase", int'(act), 0);
    bus_stop(); w(4);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule